// File: doc/BRIEF.md
# Processor Status and Special Register Bank

This block holds sixteen 32-bit special registers for a small 32-bit processor core. Software reaches them through one combinational read port and one clocked write port. Both ports use a 4-bit index. Some indices are wired to constants, and writes to those indices are dropped.

The processor status word does not sit in a single register. Eight separate flag flops supply its low byte, and a stored word supplies its upper 24 bits. The status word can be reached at two indices that alias each other. The execution unit can also update any flag on its own through a per-flag enable and value pair. The eight live flags leave the block as separate outputs so that branch logic can use them.

Top module: `spr_bank`

## Requirements
- R1: Reading index 0, 4 or 8 returns 32'h0000_0000.
- R2: Reading index 1 returns the constant 32'd10.
- R3: A write to index 0, 1, 4 or 8 changes no state. Reads of every index and the flag outputs stay as they were.
- R4: Reading index 5 or index 13 returns the stored upper 24 bits, with bits 7:0 taken from the live flags. Bit 0 is carry, bit 1 overflow, bit 2 zero, bit 3 negative, bit 4 extend, bit 5 interrupt-enable, bit 6 user-mode and bit 7 sequence-broken.
- R5: A write to index 5 or 13 loads every flag from its bit of the written value, using the bit order of R4. It also stores the upper 24 bits, so both aliases return the same word afterwards.
- R6: A write to any other index (2, 3, 6, 7, 9 to 12, 14, 15) stores the value unchanged. Later reads of that index return it.
- R7: When a flag's set-enable is high at a clock edge, that flag takes the given value. This holds even if a status write happens in the same cycle.
- R8: A synchronous active-high reset clears all stored registers and flags to zero.
- R9: Reads are combinational. A written value is visible from the cycle that follows the write edge.
- R10: The flag outputs always equal bits 7:0 of the status word read at index 5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_idx | input | 4 | Read index |
| rd_data | output | 32 | Read data (combinational) |
| wr_en | input | 1 | Write strobe |
| wr_idx | input | 4 | Write index |
| wr_data | input | 32 | Write data |
| flag_set | input | 8 | Per-flag update enables, bit order as in R4 |
| flag_val | input | 8 | Per-flag update values, bit order as in R4 |
| carry | output | 1 | Live carry flag |
| ovf | output | 1 | Live overflow flag |
| zero | output | 1 | Live zero flag |
| neg | output | 1 | Live negative flag |
| ext | output | 1 | Live extend flag |
| ie | output | 1 | Live interrupt-enable flag |
| user | output | 1 | Live user-mode flag |
| seqbrk | output | 1 | Live sequence-broken flag |

## Verification
A status-word write and a per-flag update can land on the same clock edge.

The bench provokes this collision twice. Each time it writes a pattern through index 5 or 13 and, in the same cycle, asserts enables on a subset of flags with values opposite to the written bits. It then checks that the enabled flags carry the update values. It also checks that the flags without an enable and the upper 24 bits follow the written word, both at the flag outputs and through both alias indices.

// File: rtl/spr_bank.sv
module spr_bank #(
  parameter int DW = 32,
  parameter int AW = 4,
  parameter int NF = 8,
  parameter logic [DW-1:0] VERSION = 32'd10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_idx,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  logic [DW-1:0] wr_data,
  input  logic [NF-1:0] flag_set,
  input  logic [NF-1:0] flag_val,
  output logic          carry,
  output logic          ovf,
  output logic          zero,
  output logic          neg,
  output logic          ext,
  output logic          ie,
  output logic          user,
  output logic          seqbrk
);
  localparam int N = 1 << AW;
  localparam logic [AW-1:0] ST_A = AW'(5);
  localparam logic [AW-1:0] ST_B = AW'(13);

  logic [DW-1:0] regs [N];
  logic [DW-1:NF] st_hi;
  logic [NF-1:0] flags;

  function automatic logic is_const(input logic [AW-1:0] i);
    return i == AW'(0) || i == AW'(1) || i == AW'(4) || i == AW'(8);
  endfunction

  wire st_wr = wr_en && (wr_idx == ST_A || wr_idx == ST_B);

  always_ff @(posedge clk) begin
    if (rst) begin
      st_hi <= '0;
      flags <= '0;
    end else begin
      if (st_wr) st_hi <= wr_data[DW-1:NF];
      for (int f = 0; f < NF; f++)
        if (flag_set[f]) flags[f] <= flag_val[f];
        else if (st_wr) flags[f] <= wr_data[f];
    end
  end

  for (genvar g = 0; g < N; g++) begin : g_reg
    if (is_const(AW'(g)) || AW'(g) == ST_A || AW'(g) == ST_B) begin : g_none
      assign regs[g] = '0;
    end else begin : g_store
      logic [DW-1:0] q;
      always_ff @(posedge clk)
        if (rst) q <= '0;
        else if (wr_en && wr_idx == AW'(g)) q <= wr_data;
      assign regs[g] = q;
    end
  end

  always_comb begin
    if (rd_idx == AW'(1)) rd_data = VERSION;
    else if (is_const(rd_idx)) rd_data = '0;
    else if (rd_idx == ST_A || rd_idx == ST_B) rd_data = {st_hi, flags};
    else rd_data = regs[rd_idx];
  end

  assign {seqbrk, user, ie, ext, neg, zero, ovf, carry} = flags;
endmodule

// File: rtl/spr_bank_chk.sv
module spr_bank_chk (
  input logic        clk,
  input logic        rst,
  input logic [3:0]  rd_idx,
  input logic [31:0] rd_data,
  input logic        wr_en,
  input logic [3:0]  wr_idx,
  input logic [31:0] wr_data,
  input logic [7:0]  flag_set,
  input logic [7:0]  flag_val,
  input logic [7:0]  fl
);
  a_r1_zero_idx: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == 4'd0 || rd_idx == 4'd4 || rd_idx == 4'd8) |-> rd_data == 32'd0);
  a_r2_version: assert property (@(posedge clk) disable iff (rst)
    rd_idx == 4'd1 |-> rd_data == 32'd10);
  a_r4_alias_low: assert property (@(posedge clk) disable iff (rst)
    (rd_idx == 4'd5 || rd_idx == 4'd13) |-> rd_data[7:0] == fl);
  a_r5_flag_load: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == 4'd5 || wr_idx == 4'd13) && flag_set == 8'd0)
      |=> fl == $past(wr_data[7:0]));
  a_r7_update_wins: assert property (@(posedge clk) disable iff (rst)
    flag_set != 8'd0 |=> (fl & $past(flag_set)) == ($past(flag_val) & $past(flag_set)));
  a_r3_flags_hold: assert property (@(posedge clk) disable iff (rst)
    (flag_set == 8'd0 && !(wr_en && (wr_idx == 4'd5 || wr_idx == 4'd13))) |=> $stable(fl));
  a_r8_reset: assert property (@(posedge clk) rst |=> fl == 8'd0);
endmodule

bind spr_bank spr_bank_chk u_chk (
  .clk, .rst, .rd_idx, .rd_data, .wr_en, .wr_idx, .wr_data, .flag_set, .flag_val,
  .fl({seqbrk, user, ie, ext, neg, zero, ovf, carry})
);

// File: tb/spr_bank_test.sv
module spr_bank_test;
  logic clk = 0, rst = 1;
  logic [3:0] rd_idx = 0, wr_idx = 0;
  logic [31:0] rd_data, wr_data = 0;
  logic wr_en = 0;
  logic [7:0] flag_set = 0, flag_val = 0;
  logic carry, ovf, zero, neg, ext, ie, user, seqbrk;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  spr_bank uut (.*);

  wire [7:0] fl = {seqbrk, user, ie, ext, neg, zero, ovf, carry};

  task automatic check(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] i, output logic [31:0] d);
    rd_idx = i; #1; d = rd_data;
  endtask

  task automatic wr(input logic [3:0] i, input logic [31:0] d,
                    input logic [7:0] fs = 0, input logic [7:0] fv = 0);
    @(negedge clk);
    wr_en = 1; wr_idx = i; wr_data = d; flag_set = fs; flag_val = fv;
    @(negedge clk);
    wr_en = 0; flag_set = 0; flag_val = 0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    @(negedge clk);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), d);
      check("R8", d, (i == 1) ? 32'd10 : 32'd0);
    end
    check("R8 flags", {24'd0, fl}, 0);
  endtask

  task automatic t_store;
    logic [31:0] d;
    for (int i = 0; i < 16; i++) wr(4'(i), 32'hA500_0000 + 32'(i) * 32'h0101_1111 + 32'h100);
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), d);
      if (i == 0 || i == 4 || i == 8) check("R1", d, 0);
      else if (i == 1) check("R2", d, 32'd10);
      else if (i != 5 && i != 13)
        check("R6", d, 32'hA500_0000 + 32'(i) * 32'h0101_1111 + 32'h100);
    end
  endtask

  task automatic t_const_wr;
    logic [31:0] d, s5;
    rd(4'd5, s5);
    wr(4'd0, 32'hFFFF_FFFF); wr(4'd1, 32'h1234_5678);
    wr(4'd4, 32'hDEAD_BEEF); wr(4'd8, 32'hCAFE_F00D);
    rd(4'd0, d); check("R3", d, 0);
    rd(4'd1, d); check("R3", d, 32'd10);
    rd(4'd4, d); check("R3", d, 0);
    rd(4'd8, d); check("R3", d, 0);
    rd(4'd5, d); check("R3 status", d, s5);
    rd(4'd9, d); check("R3 neighbour", d, 32'hA500_0000 + 32'd9 * 32'h0101_1111 + 32'h100);
  endtask

  task automatic t_status;
    logic [31:0] d;
    wr(4'd5, 32'h1234_56A5);
    rd(4'd5, d); check("R5", d, 32'h1234_56A5);
    rd(4'd13, d); check("R4", d, 32'h1234_56A5);
    check("R10", {24'd0, fl}, 32'hA5);
    check("R4 carry", {31'd0, carry}, 1);
    check("R4 seqbrk", {31'd0, seqbrk}, 1);
    check("R4 ovf", {31'd0, ovf}, 0);
    wr(4'd13, 32'hFEDC_BA5A);
    rd(4'd5, d); check("R5 alias", d, 32'hFEDC_BA5A);
    check("R4 user", {31'd0, user}, 1);
  endtask

  task automatic t_collide;
    logic [31:0] d;
    wr(4'd5, 32'h0F0F_0000, 8'h81, 8'h81);
    rd(4'd13, d); check("R7 collide", d, 32'h0F0F_0081);
    wr(4'd13, 32'h7777_77FF, 8'h3C, 8'h00);
    rd(4'd5, d); check("R7 collide2", d, 32'h7777_77C3);
    check("R10", {24'd0, fl}, 32'hC3);
    wr(4'd2, 32'h1111_2222, 8'h04, 8'h04);
    check("R7 solo", {31'd0, zero}, 1);
    rd(4'd2, d); check("R6", d, 32'h1111_2222);
  endtask

  task automatic t_timing;
    logic [31:0] d;
    @(negedge clk);
    wr_en = 1; wr_idx = 4'd7; wr_data = 32'hBEEF_0007; rd_idx = 4'd7; #1;
    check("R9 before edge", rd_data, 32'hA500_0000 + 32'd7 * 32'h0101_1111 + 32'h100);
    @(negedge clk); wr_en = 0;
    rd(4'd7, d); check("R9 after edge", d, 32'hBEEF_0007);
  endtask

  task automatic t_rst2;
    logic [31:0] d;
    @(negedge clk); rst = 1; @(negedge clk); rst = 0;
    rd(4'd7, d); check("R8", d, 0);
    rd(4'd13, d); check("R8", d, 0);
  endtask

  initial begin
    repeat (2) @(negedge clk);
    rst = 0;
    t_reset; t_store; t_const_wr; t_status; t_collide; t_timing; t_rst2;
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin repeat (5000) @(posedge clk); checks++; fails++; $display("FAIL watchdog"); end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule